// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block expands one multi-register memory transfer into a run of single-word accesses. A request carries a base address, a 16-bit mask that selects which registers take part, a 2-bit addressing mode and a writeback enable. The block then emits one beat per cycle over a valid/ready handshake. Each beat holds a register index and the word address for that register. After the final beat it pulses `done` and presents the new base value.

The block chooses the first address from the mode so that the selected registers always fill a contiguous run of words. The lowest-numbered register takes the lowest address. The run sits above or below the base, depending on the mode. A stack push is the decrement-before mode on the stack pointer with writeback. A pop is increment-after with writeback. Whether each beat is a load or a store is decided outside this block.

Top module: `blkxfer_seq`

## Requirements
- R1: After reset `beat_valid` and `done` are low and `req_ready` is high.
- R2: A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from the cycle after a non-empty request is taken until its last beat completes.
- R3: A request whose mask has N set bits produces exactly N beats. The beats come in ascending register index and match the set bits of the mask. `beat_last` is high only on the final beat.
- R4: Let B be the aligned base. The first beat address depends on `req_mode`: 2'b00 (increment after) gives B, 2'b01 (increment before) gives B+4, 2'b10 (decrement after) gives B-4N+4, and 2'b11 (decrement before) gives B-4N. Each later beat adds 4, modulo 2^32.
- R5: The two low bits of `req_base` are ignored, so every beat address is word aligned.
- R6: While `beat_valid` is high and `beat_ready` is low, `beat_reg`, `beat_addr` and `beat_last` hold their values.
- R7: `done` is high for exactly the one cycle after the final beat's handshake. With `req_wb` high, `base_out` then equals B+4N for modes 2'b00 and 2'b01, and B-4N for modes 2'b10 and 2'b11.
- R8: With `req_wb` low, `base_out` equals B when `done` is high.
- R9: An empty mask produces no beat. `done` is high in the cycle after acceptance, and `base_out` equals B whatever `req_wb` is.
- R10: A new request can be accepted in the same cycle that `done` is high for the previous one. The new transfer then runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_base | input | 32 | Base address (low two bits ignored) |
| req_mask | input | 16 | Register-select mask, bit i selects register i |
| req_mode | input | 2 | 00 inc-after, 01 inc-before, 10 dec-after, 11 dec-before |
| req_wb | input | 1 | Writeback enable |
| beat_valid | output | 1 | Beat present |
| beat_ready | input | 1 | Consumer takes the beat |
| beat_reg | output | 4 | Register index of the beat |
| beat_addr | output | 32 | Word address of the beat |
| beat_last | output | 1 | Final beat of the transfer |
| done | output | 1 | One-cycle completion pulse |
| base_out | output | 32 | Updated base, valid while done is high |

## Verification
Two events can fall in the same cycle: the completion pulse of one transfer and the acceptance of the next request. The bench provokes this by driving a new request in the very cycle it observes `done`. It judges the overlap in two ways. The pulse and `base_out` must still match the earlier request. The following transfer must then yield the beats and final base computed for its own request. Random back-pressure on `beat_ready` and empty-mask requests are mixed into these chains, so a completion can also coincide with a zero-beat request that finishes again at once.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;
  typedef enum logic [1:0] {
    MODE_INC_AFTER  = 2'b00,
    MODE_INC_BEFORE = 2'b01,
    MODE_DEC_AFTER  = 2'b10,
    MODE_DEC_BEFORE = 2'b11
  } xfer_mode_e;
endpackage

// File: rtl/blkxfer_popcnt.sv
module blkxfer_popcnt #(
  parameter int NREG = 16,
  localparam int CW = $clog2(NREG + 1)
) (
  input  logic [NREG-1:0] mask,
  output logic [CW-1:0]   count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < NREG; i++) begin
      count = count + CW'(mask[i]);
    end
  end
endmodule

// File: rtl/blkxfer_lowpick.sv
module blkxfer_lowpick #(
  parameter int NREG = 16,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic [NREG-1:0] mask,
  output logic [NREG-1:0] onehot,
  output logic [IDXW-1:0] idx,
  output logic            only
);
  logic [NREG-1:0] below;

  // below[i] is set when some bit under position i is set
  assign below[0] = 1'b0;
  for (genvar g = 1; g < NREG; g++) begin : g_chain
    assign below[g] = below[g-1] | mask[g-1];
  end

  assign onehot = mask & ~below;

  always_comb begin
    idx = '0;
    for (int i = 0; i < NREG; i++) begin
      if (onehot[i]) idx = IDXW'(i);
    end
  end

  assign only = ((mask & ~onehot) == '0);
endmodule

// File: rtl/blkxfer_addr_calc.sv
module blkxfer_addr_calc
  import blkxfer_pkg::*;
#(
  parameter int AW         = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4,
  localparam int CW = $clog2(NREG + 1),
  localparam int SH = $clog2(WORD_BYTES)
) (
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] count,
  input  xfer_mode_e    mode,
  input  logic          wb,
  output logic [AW-1:0] start_addr,
  output logic [AW-1:0] final_base
);
  logic [AW-1:0] aligned;
  logic [AW-1:0] span;
  logic [AW-1:0] step;

  assign aligned = {base[AW-1:SH], {SH{1'b0}}};
  assign span    = AW'(count) << SH;
  assign step    = AW'(WORD_BYTES);

  always_comb begin
    unique case (mode)
      MODE_INC_AFTER:  start_addr = aligned;
      MODE_INC_BEFORE: start_addr = aligned + step;
      MODE_DEC_AFTER:  start_addr = aligned - span + step;
      default:         start_addr = aligned - span;
    endcase
  end

  always_comb begin
    if (!wb)          final_base = aligned;
    else if (mode[1]) final_base = aligned - span;
    else              final_base = aligned + span;
  end
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
  import blkxfer_pkg::*;
#(
  parameter int AW         = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4,
  localparam int CW   = $clog2(NREG + 1),
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_base,
  input  logic [NREG-1:0] req_mask,
  input  logic [1:0]      req_mode,
  input  logic            req_wb,
  output logic            beat_valid,
  input  logic            beat_ready,
  output logic [IDXW-1:0] beat_reg,
  output logic [AW-1:0]   beat_addr,
  output logic            beat_last,
  output logic            done,
  output logic [AW-1:0]   base_out
);
  logic            busy_q, busy_d;
  logic            done_q, done_d;
  logic [NREG-1:0] mask_q, mask_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic [AW-1:0]   wbv_q, wbv_d;
  logic            ld_en;

  logic [CW-1:0]   req_cnt;
  logic [AW-1:0]   calc_start, calc_final;
  logic [NREG-1:0] pick_oh;
  logic [IDXW-1:0] pick_idx;
  logic            pick_only;
  logic            accept, fire;

  blkxfer_popcnt #(.NREG(NREG)) u_cnt (
    .mask  (req_mask),
    .count (req_cnt)
  );

  blkxfer_addr_calc #(.AW(AW), .NREG(NREG), .WORD_BYTES(WORD_BYTES)) u_calc (
    .base       (req_base),
    .count      (req_cnt),
    .mode       (xfer_mode_e'(req_mode)),
    .wb         (req_wb),
    .start_addr (calc_start),
    .final_base (calc_final)
  );

  blkxfer_lowpick #(.NREG(NREG)) u_pick (
    .mask   (mask_q),
    .onehot (pick_oh),
    .idx    (pick_idx),
    .only   (pick_only)
  );

  assign accept = req_valid & ~busy_q;
  assign fire   = busy_q & beat_ready;
  assign ld_en  = accept | fire;

  always_comb begin
    busy_d = busy_q;
    mask_d = mask_q;
    addr_d = addr_q;
    wbv_d  = wbv_q;
    done_d = 1'b0;
    if (accept) begin
      wbv_d = calc_final;
      if (req_mask != '0) begin
        busy_d = 1'b1;
        mask_d = req_mask;
        addr_d = calc_start;
      end else begin
        done_d = 1'b1;
      end
    end
    if (fire) begin
      mask_d = mask_q & ~pick_oh;
      addr_d = addr_q + AW'(WORD_BYTES);
      if (pick_only) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      addr_q <= '0;
      wbv_q  <= '0;
    end else if (ld_en) begin
      mask_q <= mask_d;
      addr_q <= addr_d;
      wbv_q  <= wbv_d;
    end
  end

  assign req_ready  = ~busy_q;
  assign beat_valid = busy_q;
  assign beat_reg   = pick_idx;
  assign beat_addr  = addr_q;
  assign beat_last  = pick_only;
  assign done       = done_q;
  assign base_out   = wbv_q;

  AST_REG_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready && !beat_last) |=> (beat_valid && beat_reg > $past(beat_reg))); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready && !beat_last) |=> (beat_addr == $past(beat_addr) + AW'(WORD_BYTES))); // R4
  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (beat_addr[1:0] == 2'b00)); // R5
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_addr) && $stable(beat_reg) && $stable(beat_last))); // R6
  AST_LAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready && beat_last) |=> (done && !beat_valid)); // R7
  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |=> $stable(base_out)); // R7
  AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mask == '0) |=> (done && !beat_valid)); // R9
endmodule

// File: tb/blkxfer_seq_bench.sv
module blkxfer_seq_bench;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_base;
  logic [15:0] req_mask;
  logic [1:0]  req_mode;
  logic        req_wb;
  logic        beat_valid;
  logic        beat_ready;
  logic [3:0]  beat_reg;
  logic [31:0] beat_addr;
  logic        beat_last;
  logic        done;
  logic [31:0] base_out;

  int total = 0;
  int bad   = 0;

  blkxfer_seq u_blkxfer_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_base(req_base), .req_mask(req_mask), .req_mode(req_mode), .req_wb(req_wb),
    .beat_valid(beat_valid), .beat_ready(beat_ready),
    .beat_reg(beat_reg), .beat_addr(beat_addr), .beat_last(beat_last),
    .done(done), .base_out(base_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic int nbits(input logic [15:0] m);
    int n = 0;
    for (int i = 0; i < 16; i++) n += int'(m[i]);
    return n;
  endfunction

  function automatic logic [3:0] kth_reg(input logic [15:0] m, input int k);
    int seen = 0;
    for (int i = 0; i < 16; i++) begin
      if (m[i]) begin
        if (seen == k) return 4'(i);
        seen++;
      end
    end
    return 4'd0;
  endfunction

  function automatic logic [31:0] first_addr(input logic [31:0] b, input logic [15:0] m, input logic [1:0] md);
    logic [31:0] a = {b[31:2], 2'b00};
    logic [31:0] s = 32'(nbits(m)) * 32'd4;
    case (md)
      2'b00:   return a;
      2'b01:   return a + 32'd4;
      2'b10:   return a - s + 32'd4;
      default: return a - s;
    endcase
  endfunction

  function automatic logic [31:0] end_base(input logic [31:0] b, input logic [15:0] m, input logic [1:0] md, input logic w);
    logic [31:0] a = {b[31:2], 2'b00};
    logic [31:0] s = 32'(nbits(m)) * 32'd4;
    if (!w) return a;
    return md[1] ? a - s : a + s;
  endfunction

  // called at a negedge with the block expected idle
  task automatic start_req(input logic [31:0] b, input logic [15:0] m, input logic [1:0] md, input logic w, input bit overlap);
    check(req_ready === 1'b1, overlap ? "R10 ready during done" : "R2 ready when idle", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_base = b; req_mask = m; req_mode = md; req_wb = w;
  endtask

  // returns at the negedge where done is expected high
  task automatic finish_req(input logic [31:0] b, input logic [15:0] m, input logic [1:0] md, input logic w, input int pready);
    int n = nbits(m);
    int k = 0;
    int guard = 0;
    bit stalled = 0;
    logic [31:0] st = first_addr(b, m, md);
    @(negedge clk);
    req_valid = 1'b0;
    if (n == 0) begin
      check(done === 1'b1, "R9 done after empty", 32'(done), 32'd1);
      check(beat_valid === 1'b0, "R9 no beat", 32'(beat_valid), 32'd0);
      check(base_out === {b[31:2], 2'b00}, "R9 base kept", base_out, {b[31:2], 2'b00});
      return;
    end
    check(req_ready === 1'b0, "R2 busy not ready", 32'(req_ready), 32'd0);
    while (guard < 2000) begin
      guard++;
      if (beat_valid !== 1'b1) begin
        check(1'b0, "R3 beat missing", 32'(beat_valid), 32'd1);
        break;
      end
      check(beat_reg === kth_reg(m, k), stalled ? "R6 reg held" : "R3 reg order", 32'(beat_reg), 32'(kth_reg(m, k)));
      check(beat_addr === st + 32'(k) * 32'd4, stalled ? "R6 addr held" : "R4 addr", beat_addr, st + 32'(k) * 32'd4);
      check(beat_addr[1:0] === 2'b00, "R5 aligned", beat_addr, {beat_addr[31:2], 2'b00});
      check(beat_last === (k == n - 1), "R3 last flag", 32'(beat_last), 32'(k == n - 1));
      beat_ready = (($urandom % 100) < 32'(pready));
      if (beat_ready) begin
        k++;
        stalled = 0;
        if (k == n) break;
      end else begin
        stalled = 1;
      end
      @(negedge clk);
      check(done === 1'b0, "R7 no early done", 32'(done), 32'd0);
    end
    @(negedge clk);
    beat_ready = 1'b0;
    check(done === 1'b1, "R7 done pulse", 32'(done), 32'd1);
    check(beat_valid === 1'b0, "R3 no extra beat", 32'(beat_valid), 32'd0);
    check(base_out === end_base(b, m, md, w), w ? "R7 writeback" : "R8 base kept", base_out, end_base(b, m, md, w));
  endtask

  task automatic run(input logic [31:0] b, input logic [15:0] m, input logic [1:0] md, input logic w, input int pready, input bit overlap);
    if (!overlap) begin
      @(negedge clk);
      check(done === 1'b0, "R7 single-cycle done", 32'(done), 32'd0);
    end
    start_req(b, m, md, w, overlap);
    finish_req(b, m, md, w, pready);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    rst_n = 1'b0; req_valid = 1'b0; req_base = '0; req_mask = '0; req_mode = '0; req_wb = 1'b0; beat_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(beat_valid === 1'b0, "R1 beat_valid reset", 32'(beat_valid), 32'd0);
    check(done === 1'b0, "R1 done reset", 32'(done), 32'd0);
    check(req_ready === 1'b1, "R1 ready reset", 32'(req_ready), 32'd1);

    run(32'h0000_1000, 16'h4013, 2'b11, 1'b1, 100, 1'b0);   // push-like, R4 R7
    run(32'h0000_0FEC, 16'h4013, 2'b00, 1'b1, 100, 1'b0);   // pop-like
    run(32'h2000_0003, 16'h0005, 2'b01, 1'b0, 100, 1'b0);   // R5 R8
    run(32'h0000_0010, 16'hFFFF, 2'b10, 1'b1, 40, 1'b0);    // all regs, stalls, R6
    run(32'h0000_0000, 16'h8000, 2'b11, 1'b1, 100, 1'b0);   // wrap below zero
    run(32'h1234_5679, 16'h0000, 2'b00, 1'b1, 100, 1'b0);   // R9
    run(32'h0000_0100, 16'h0001, 2'b01, 1'b1, 100, 1'b1);   // R10 overlap
    run(32'h0000_0200, 16'h0000, 2'b10, 1'b1, 100, 1'b1);   // R10 with empty
    run(32'hFFFF_FFF8, 16'h00F0, 2'b00, 1'b1, 60, 1'b1);    // wrap above top

    for (int it = 0; it < 300; it++) begin
      logic [15:0] m = 16'($urandom);
      if (($urandom % 8) == 0) m = '0;
      run($urandom, m, 2'($urandom), 1'($urandom), 30 + int'($urandom % 71), 1'($urandom));
    end

    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule